// File: doc/BRIEF.md
# Write-Once System Option Register with Stop-Recovery Timer

This block holds the chip's start-up options in one byte-wide register on a simple peripheral bus. Software gets a single write after each reset; every later write is dropped until a reset reopens the register. Reads are allowed at any time. Two reset inputs cover two domains. The power-on/low-voltage reset clears the whole register. The general reset clears only the lower option bits and the write lock.

The stored bits drive actions directly. One bit decides what happens when a USB bus-reset event arrives. The event either raises a sticky interrupt request, which software clears with an acknowledge input, or it produces a one-cycle chip reset request. Another bit drives the low-voltage detector disable output. A third bit picks the length of the stop-mode recovery delay, which the block times itself. A one-cycle wake pulse starts the count, and a one-cycle resume pulse marks its end. The remaining low bits leave the block as plain option outputs.

Top module: `sysopt_lockreg`

## Requirements
- R1: After any reset, the first bus write to the register's address is stored. Every later write leaves the register unchanged until the next reset of either kind.
- R2: The register answers only at bus address 0x1F. A write to any other address changes nothing. A read at any other address returns 0x00.
- R3: A read at address 0x1F returns the stored bits 5..0, and bits 7 and 6 always read as 0.
- R4: Bit 5 (USB event routing) and bit 4 (low-voltage detector disable) are cleared only by the power reset `rst_pwr_n`. The general reset `rst_any_n` leaves them unchanged.
- R5: Bits 3..0 and the write lock are cleared by either reset input.
- R6: `lvd_disable` equals bit 4, and `opt_bits` equals bits 2..0.
- R7: With bit 5 = 1, a USB bus-reset event sets `usb_irq_req` on the next cycle. The flag holds until a cycle with `usb_irq_ack` high and no new event. If a new event and the acknowledge arrive in the same cycle, the flag stays set. No chip reset request is raised.
- R8: With bit 5 = 0, a USB bus-reset event makes `chip_rst_req` high for exactly the one cycle after the event, and `usb_irq_req` stays low.
- R9: A wake pulse accepted while idle makes `resume_pulse` high for one cycle. That cycle comes N cycles after the wake was sampled, with N = 2048 when bit 3 is 1 and N = 4096 when bit 3 is 0. `recovery_busy` is high from the cycle after the wake until the resume cycle.
- R10: A wake pulse that arrives while a recovery count is running is ignored and does not restart the count.
- R11: The delay length is taken from bit 3 at the moment the wake is accepted. A register write during the count does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock for the register and the timer |
| rst_pwr_n | input | 1 | Power-on / low-voltage reset, active low, synchronous |
| rst_any_n | input | 1 | General reset, active low, synchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| usb_busrst_evt | input | 1 | One-cycle USB bus-reset event |
| usb_irq_ack | input | 1 | Clears the USB interrupt request |
| usb_irq_req | output | 1 | Sticky USB interrupt request |
| chip_rst_req | output | 1 | One-cycle chip reset request |
| lvd_disable | output | 1 | Low-voltage detector disable |
| opt_bits | output | 3 | Option bits 2..0 |
| wake_pulse | input | 1 | One-cycle stop-mode wake request |
| recovery_busy | output | 1 | Recovery count in progress |
| resume_pulse | output | 1 | One-cycle end of recovery |

## Verification
A lock flag stuck open shows at the next read as a second write value leaking through. A lock stuck closed shows as the first value after reset being missing. A wrong reset domain on bits 5 or 4 shows on `lvd_disable` and in the USB routing right after a general reset. The routing is checked one cycle after each event. Errors in the count or in the sampled delay select move `resume_pulse` by a measurable number of cycles, or make it early, late or missing. The bench counts every cycle from the wake to the resume and compares the total exactly.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

  // Stored option bits, most significant first: bits 5..0 of the register
  typedef struct packed {
    logic       usb_irq_mode;   // bit 5
    logic       lvd_off;        // bit 4
    logic       short_rec;      // bit 3
    logic [2:0] misc;           // bits 2..0
  } sysopt_cfg_t;

  localparam int CFG_W = 6;

  // Recovery length in clock cycles for a given select bit
  function automatic int rec_len(input logic short_sel, input int short_cyc, input int long_cyc);
    return short_sel ? short_cyc : long_cyc;
  endfunction

  // Read view: unimplemented top bits are zero
  function automatic logic [7:0] read_view(input sysopt_cfg_t c);
    return {2'b00, c};
  endfunction

endpackage

// File: rtl/sysopt_cfg_store.sv
module sysopt_cfg_store
  import sysopt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_pwr_n,
  input  logic        rst_any_n,
  input  logic        wr_hit,
  input  logic [7:0]  wdata,
  output sysopt_cfg_t cfg,
  output logic        locked
);

  sysopt_cfg_t cfg_q;
  logic        lock_q;
  logic        accept;
  logic        unused_hi;

  assign unused_hi = ^wdata[7:6];
  assign accept    = wr_hit && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_pwr_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else if (!rst_any_n) begin
      cfg_q.short_rec <= 1'b0;
      cfg_q.misc      <= '0;
      lock_q          <= 1'b0;
    end else if (accept) begin
      cfg_q  <= sysopt_cfg_t'(wdata[CFG_W-1:0]);
      lock_q <= 1'b1;
    end
  end

  assign cfg    = cfg_q;
  assign locked = lock_q;

  // R1: a locked register does not move
  a_r1_locked_stable: assert property (@(posedge clk) disable iff (!rst_pwr_n || !rst_any_n)
    lock_q |=> $stable(cfg_q));

  // R1: lock stays set until a reset
  a_r1_lock_sticky: assert property (@(posedge clk) disable iff (!rst_pwr_n || !rst_any_n)
    lock_q |=> lock_q);

  // R4: general reset keeps the upper two bits
  a_r4_hi_survive: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    !rst_any_n |=> (cfg_q.usb_irq_mode == $past(cfg_q.usb_irq_mode)) && (cfg_q.lvd_off == $past(cfg_q.lvd_off)));

  // R5: general reset clears the low bits and the lock
  a_r5_low_clear: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    !rst_any_n |=> (!cfg_q.short_rec && cfg_q.misc == 3'b000 && !lock_q));

endmodule

// File: rtl/sysopt_usb_route.sv
module sysopt_usb_route (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic irq_mode,
  input  logic ack,
  output logic irq_req,
  output logic chip_rst_req
);

  logic irq_q;
  logic rst_pls_q;
  logic set_irq;
  logic set_rst;

  assign set_irq = evt && irq_mode;
  assign set_rst = evt && !irq_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      rst_pls_q <= 1'b0;
    end else begin
      rst_pls_q <= set_rst;
      if (set_irq)  irq_q <= 1'b1;
      else if (ack) irq_q <= 1'b0;
    end
  end

  assign irq_req      = irq_q;
  assign chip_rst_req = rst_pls_q;

  // R7: flag holds without acknowledge
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !ack |=> irq_q);

  // R7: an event in interrupt mode always leaves the flag set
  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt && irq_mode |=> irq_q);

  // R8: a chip reset pulse has a cause in reset-routing mode
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pls_q |-> $past(evt && !irq_mode));

endmodule

// File: rtl/sysopt_stop_timer.sv
module sysopt_stop_timer
  import sysopt_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic short_sel,
  output logic busy,
  output logic resume
);

  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             res_q;
  logic             start;
  logic             done;
  logic [CNT_W-1:0] load_val;

  assign start    = wake && !busy_q;
  assign done     = busy_q && (cnt_q == '0);
  assign load_val = CNT_W'(rec_len(short_sel, SHORT_CYC, LONG_CYC) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      res_q <= done;
      if (start) begin
        cnt_q  <= load_val;
        busy_q <= 1'b1;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign resume = res_q;

  // R9: resume coincides with the end of the busy window
  a_r9_resume_idle: assert property (@(posedge clk) disable iff (!rst_n)
    res_q |-> !busy_q);

  // R9: resume is a single cycle
  a_r9_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_q |=> !res_q);

  // R10: a running count is neither dropped nor restarted by wake
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt_q != '0 |=> busy_q && (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sysopt_lockreg.sv
module sysopt_lockreg
  import sysopt_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REG_ADDR  = 8'h1F,
  parameter int          LONG_CYC  = 4096,
  parameter int          SHORT_CYC = 2048
) (
  input  logic              clk,
  input  logic              rst_pwr_n,
  input  logic              rst_any_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              usb_busrst_evt,
  input  logic              usb_irq_ack,
  output logic              usb_irq_req,
  output logic              chip_rst_req,
  output logic              lvd_disable,
  output logic [2:0]        opt_bits,
  input  logic              wake_pulse,
  output logic              recovery_busy,
  output logic              resume_pulse
);

  sysopt_cfg_t cfg;
  logic        addr_hit;
  logic        wr_hit;
  logic        locked;
  logic        rst_gen_n;

  assign rst_gen_n = rst_pwr_n && rst_any_n;
  assign addr_hit  = bus_sel && (bus_addr == ADDR_W'(REG_ADDR));
  assign wr_hit    = addr_hit && bus_wr;

  sysopt_cfg_store u_store (
    .clk       (clk),
    .rst_pwr_n (rst_pwr_n),
    .rst_any_n (rst_any_n),
    .wr_hit    (wr_hit),
    .wdata     (bus_wdata),
    .cfg       (cfg),
    .locked    (locked)
  );

  sysopt_usb_route u_route (
    .clk          (clk),
    .rst_n        (rst_gen_n),
    .evt          (usb_busrst_evt),
    .irq_mode     (cfg.usb_irq_mode),
    .ack          (usb_irq_ack),
    .irq_req      (usb_irq_req),
    .chip_rst_req (chip_rst_req)
  );

  sysopt_stop_timer #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_gen_n),
    .wake      (wake_pulse),
    .short_sel (cfg.short_rec),
    .busy      (recovery_busy),
    .resume    (resume_pulse)
  );

  assign bus_rdata   = (addr_hit && !bus_wr) ? read_view(cfg) : 8'h00;
  assign lvd_disable = cfg.lvd_off;
  assign opt_bits    = cfg.misc;

  // R7/R8: the two routing outputs never start in the same cycle
  a_r8_route_exclusive: assert property (@(posedge clk) disable iff (!rst_gen_n)
    chip_rst_req |-> !$rose(usb_irq_req));

  // R1: a write accepted while unlocked locks the register
  a_r1_write_locks: assert property (@(posedge clk) disable iff (!rst_gen_n)
    wr_hit |=> locked);

endmodule

// File: tb/sysopt_lockreg_tb_top.sv
module sysopt_lockreg_tb_top;

  logic       clk = 1'b0;
  logic       rst_pwr_n = 1'b0, rst_any_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic       usb_busrst_evt = 0, usb_irq_ack = 0, usb_irq_req, chip_rst_req;
  logic       lvd_disable, recovery_busy, resume_pulse, wake_pulse = 0;
  logic [2:0] opt_bits;

  int n_chk = 0, n_bad = 0;
  logic [5:0] model = '0;
  bit done_flag = 0;

  always #10ns clk = ~clk;

  sysopt_lockreg dut_i (
    .clk(clk), .rst_pwr_n(rst_pwr_n), .rst_any_n(rst_any_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .usb_busrst_evt(usb_busrst_evt), .usb_irq_ack(usb_irq_ack),
    .usb_irq_req(usb_irq_req), .chip_rst_req(chip_rst_req),
    .lvd_disable(lvd_disable), .opt_bits(opt_bits),
    .wake_pulse(wake_pulse), .recovery_busy(recovery_busy),
    .resume_pulse(resume_pulse)
  );

  function automatic int exp_delay(input logic sel);
    if (sel == 1'b1) return 2048;
    return 4096;
  endfunction

  function automatic logic [7:0] exp_read(input logic [5:0] m, input logic [7:0] a);
    if (a != 8'h1F) return 8'h00;
    return {2'b00, m};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pwr_reset();
    rst_pwr_n = 0; step(); rst_pwr_n = 1;
    model = '0;
  endtask

  task automatic gen_reset();
    rst_any_n = 0; step(); rst_any_n = 1;
    model = model & 6'b110000;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic read_check(input string tag, input logic [7:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1ns;
    check(tag, bus_rdata, exp_read(model, a));
    bus_sel = 0;
  endtask

  task automatic outs_check(input string tag);
    check({tag, " lvd"}, lvd_disable, model[4]);
    check({tag, " opt"}, opt_bits, model[2:0]);
  endtask

  task automatic measure(input string tag, input int exp_n, input bit rewake);
    int k = 0;
    wake_pulse = 1; step(); wake_pulse = 0;
    check({tag, " busy"}, recovery_busy, 1);
    while (k < 6000) begin
      if (rewake && k == 100) wake_pulse = 1;
      step();
      wake_pulse = 0;
      k++;
      if (resume_pulse) break;
    end
    check({tag, " delay"}, k, exp_n);
    check({tag, " busy end"}, recovery_busy, 0);
    step();
    check({tag, " single"}, resume_pulse, 0);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, a;
    void'($urandom(32'h5EED_1F1F));
    step(); step();
    rst_pwr_n = 1; rst_any_n = 1;
    model = '0;
    // reset state
    read_check("R3 reset read", 8'h1F);
    check("R7 reset irq", usb_irq_req, 0);
    check("R8 reset rstreq", chip_rst_req, 0);
    check("R9 reset busy", recovery_busy, 0);
    outs_check("R6 reset");

    // directed: lock and address decode
    bus_write(8'h1E, 8'h3F);
    read_check("R2 wrong addr write", 8'h1F);
    read_check("R2 other addr read", 8'h1E);
    bus_write(8'h1F, 8'hFF);
    model = 6'h3F;
    read_check("R3 top bits zero", 8'h1F);
    bus_write(8'h1F, 8'h00);
    read_check("R1 second write ignored", 8'h1F);
    outs_check("R1 R6 after lock");
    gen_reset();
    read_check("R4 R5 general reset", 8'h1F);
    check("R4 lvd kept", lvd_disable, 1);
    bus_write(8'h1F, 8'h0A);
    model = 6'h0A;
    read_check("R5 lock reopened", 8'h1F);

    // random rounds
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 1) == 0) pwr_reset(); else gen_reset();
      read_check("R4 R5 rand reset", 8'h1F);
      a = 8'($urandom_range(0, 255));
      if (a != 8'h1F) begin
        bus_write(a, 8'($urandom));
        read_check("R2 rand other addr", 8'h1F);
      end
      d = 8'($urandom);
      bus_write(8'h1F, d);
      model = d[5:0];
      read_check("R1 rand first write", 8'h1F);
      bus_write(8'h1F, ~d);
      read_check("R1 rand later write", 8'h1F);
      outs_check("R6 rand");
    end

    // USB routing, interrupt mode
    pwr_reset();
    bus_write(8'h1F, 8'h20); model = 6'h20;
    usb_busrst_evt = 1; step(); usb_busrst_evt = 0;
    check("R7 irq set", usb_irq_req, 1);
    check("R7 no rstreq", chip_rst_req, 0);
    step(); step();
    check("R7 irq sticky", usb_irq_req, 1);
    usb_busrst_evt = 1; usb_irq_ack = 1; step(); usb_busrst_evt = 0;
    check("R7 set beats ack", usb_irq_req, 1);
    step(); usb_irq_ack = 0;
    check("R7 ack clears", usb_irq_req, 0);
    gen_reset();
    usb_busrst_evt = 1; step(); usb_busrst_evt = 0;
    check("R4 routing kept after general reset", usb_irq_req, 1);
    usb_irq_ack = 1; step(); usb_irq_ack = 0;

    // USB routing, reset mode
    pwr_reset();
    bus_write(8'h1F, 8'h00);
    usb_busrst_evt = 1; step(); usb_busrst_evt = 0;
    check("R8 rstreq pulse", chip_rst_req, 1);
    check("R8 no irq", usb_irq_req, 0);
    step();
    check("R8 rstreq one cycle", chip_rst_req, 0);

    // recovery timer
    pwr_reset();
    bus_write(8'h1F, 8'h08); model = 6'h08;
    measure("R9 short", exp_delay(1'b1), 0);
    measure("R10 rewake short", exp_delay(1'b1), 1);
    gen_reset();
    measure("R9 long", exp_delay(1'b0), 0);
    gen_reset();
    begin
      int k = 0;
      wake_pulse = 1; step(); wake_pulse = 0;
      bus_write(8'h1F, 8'h08);
      k = 1;
      while (k < 6000) begin
        if (resume_pulse) break;
        step(); k++;
      end
      check("R11 delay sampled at wake", k, exp_delay(1'b0));
    end
    step();
    measure("R11 new select used", exp_delay(1'b1), 0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule